// File: doc/BRIEF.md
# Signed 64/32 Iterative Divider

This block is the divide step of a processor execution unit. It accepts a signed dividend that is either one 32-bit word (narrow mode) or a 64-bit value built from two words (wide mode), together with a 32-bit signed divisor. It produces a 32-bit quotient and a 32-bit remainder, using a restoring shift-subtract loop on magnitudes that yields one quotient bit per clock. Signs are applied once the loop has finished.

The surrounding pipeline supplies two register selects with the operands. The quotient goes back to the low-word register. The remainder goes to the second register, which in wide mode also supplies the high word of the dividend. The block returns both selects with the results and raises one write enable for each. A quotient that does not fit the 32-bit signed range raises an overflow flag. A zero divisor raises a divide-by-zero flag. In both cases nothing is written back.

A one-cycle `start` launches an operation when the block is idle. `busy` stays high while the loop runs, and `done` pulses once when the results are ready.

Top module: `sdiv64_unit`

## Requirements
- R1: With `wide` = 0 the dividend is `lo_word` read as a signed 32-bit value, and `hi_word` has no effect. With `wide` = 1 the dividend is the signed 64-bit value with `hi_word` in bits 63:32 and `lo_word` in bits 31:0.
- R2: The quotient is the true quotient of the signed operands rounded toward zero. The remainder carries the sign of the dividend, so dividend = quotient × divisor + remainder.
- R3: When the true quotient is above 2^31−1 or below −2^31, `ovf` is high with `done`, both write enables stay low, and `quotient` and `remainder` read 0. Quotients of exactly 2^31−1 and −2^31 do not set `ovf`.
- R4: A zero divisor sets `dz` with `done`, both write enables stay low, and both results read 0. `done` arrives on the first clock edge after the accepting edge.
- R5: `quo_we` pulses together with `done` only when neither `ovf` nor `dz` is set. `rem_we` pulses under the same condition, and only when the two captured selects differ.
- R6: `start` is accepted on an edge where `busy` is low. `busy` is high from that edge until the edge that raises `done`. For a nonzero divisor, `done` is a one-cycle pulse 65 edges after the accepting edge.
- R7: A `start` raised while `busy` is high is ignored, and so are operand changes after acceptance. The results and the latency belong to the accepted operation.
- R8: After reset, `busy`, `done`, `quo_we`, `rem_we`, `ovf` and `dz` are all low.
- R9: `quo_wsel` and `rem_wsel` return the `quo_sel` and `rem_sel` values captured on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, taken only when idle |
| wide | input | 1 | 0: 32-bit dividend, 1: 64-bit dividend |
| lo_word | input | W | Dividend low word (narrow-mode dividend) |
| hi_word | input | W | Dividend high word, used in wide mode |
| divisor | input | W | Signed divisor |
| quo_sel | input | SELW | Register that receives the quotient |
| rem_sel | input | SELW | Register that receives the remainder |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | W | Signed quotient, held until the next launch |
| remainder | output | W | Signed remainder, held until the next launch |
| ovf | output | 1 | Quotient out of 32-bit signed range |
| dz | output | 1 | Divisor was zero |
| quo_we | output | 1 | Quotient write enable |
| rem_we | output | 1 | Remainder write enable |
| quo_wsel | output | SELW | Captured quotient register select |
| rem_wsel | output | SELW | Captured remainder register select |

## Verification
Counting from the edge that accepts `start`, `busy` is due one edge later, and the results, flags and write enables are due 65 edges later, or one edge later for a zero divisor. `done` and the write enables must be low again one edge after that. Inputs change only on falling edges, so the bench counts falling edges after acceptance and expects `done` at exactly the computed count. It reads every result at that same falling edge and reads the strobes once more at the next one. A checker bound to the top module keeps its own edge counter, so every `done`, including those from operations the bench does not time, must land at the same distance from its launch.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Control states of the divide sequencer.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } sdiv_state_e;

endpackage

// File: rtl/sdiv_prep.sv
// Turns the raw operands into sign flags and unsigned magnitudes.
module sdiv_prep #(
   parameter int W = 32
) (
   input  logic           wide,
   input  logic [W-1:0]   lo_word,
   input  logic [W-1:0]   hi_word,
   input  logic [W-1:0]   divisor,
   output logic [2*W-1:0] dvd_mag,
   output logic           dvd_neg,
   output logic [W-1:0]   dvs_mag,
   output logic           dvs_neg,
   output logic           dvs_zero
);
   localparam int DW = 2 * W;

   logic [DW-1:0] dvd_full;

   // Narrow mode sign-extends the low word to the full loop width.
   assign dvd_full = wide ? {hi_word, lo_word} : {{W{lo_word[W-1]}}, lo_word};

   assign dvd_neg  = dvd_full[DW-1];
   assign dvd_mag  = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;

   assign dvs_neg  = divisor[W-1];
   assign dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
   assign dvs_zero = (divisor == '0);

endmodule

// File: rtl/sdiv_core.sv
// Restoring divider on magnitudes: one quotient bit per clock, 2*W steps.
module sdiv_core #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [2*W-1:0] dvd_mag,
   input  logic [W-1:0]   dvs_mag,
   output logic           last,
   output logic [2*W-1:0] q_mag,
   output logic [W-1:0]   r_mag
);
   localparam int DW    = 2 * W;
   localparam int STEPS = DW;
   localparam int CW    = $clog2(STEPS + 1);

   logic [W-1:0]  rem_q;
   logic [DW-1:0] quo_q;
   logic [W-1:0]  dvs_q;
   logic [CW-1:0] cnt_q;
   logic          active_q;

   logic [W:0]    shifted;
   logic          fits;
   logic [W-1:0]  rem_nx;

   assign shifted = {rem_q, quo_q[DW-1]};
   assign fits    = (shifted >= {1'b0, dvs_q});
   assign rem_nx  = fits ? W'(shifted - {1'b0, dvs_q}) : shifted[W-1:0];
   assign last    = active_q && (cnt_q == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         quo_q    <= '0;
         dvs_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         rem_q    <= '0;
         quo_q    <= dvd_mag;
         dvs_q    <= dvs_mag;
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (active_q) begin
         rem_q <= rem_nx;
         quo_q <= {quo_q[DW-2:0], fits};
         cnt_q <= cnt_q + 1'b1;
         if (last) begin
            active_q <= 1'b0;
         end
      end
   end

   assign q_mag = quo_q;
   assign r_mag = rem_q;

endmodule

// File: rtl/sdiv_fixup.sv
// Applies signs, checks the 32-bit signed range, blanks faulted results.
module sdiv_fixup #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] q_mag,
   input  logic [W-1:0]   r_mag,
   input  logic           q_neg,
   input  logic           r_neg,
   input  logic           zero,
   output logic [W-1:0]   quotient,
   output logic [W-1:0]   remainder,
   output logic           ovf
);
   localparam int DW = 2 * W;

   logic hi_any;
   logic top_bit;
   logic low_any;
   logic fault;

   assign hi_any  = |q_mag[DW-1:W];
   assign top_bit = q_mag[W-1];
   assign low_any = |q_mag[W-2:0];

   // A negative quotient may reach magnitude 2^(W-1); a positive one may not.
   assign ovf   = !zero && (hi_any || (q_neg ? (top_bit && low_any) : top_bit));
   assign fault = zero || ovf;

   assign quotient  = fault ? '0 : (q_neg ? (~q_mag[W-1:0] + 1'b1) : q_mag[W-1:0]);
   assign remainder = fault ? '0 : (r_neg ? (~r_mag + 1'b1) : r_mag);

endmodule

// File: rtl/sdiv64_unit.sv
module sdiv64_unit #(
   parameter int W    = 32,
   parameter int SELW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            wide,
   input  logic [W-1:0]    lo_word,
   input  logic [W-1:0]    hi_word,
   input  logic [W-1:0]    divisor,
   input  logic [SELW-1:0] quo_sel,
   input  logic [SELW-1:0] rem_sel,
   output logic            busy,
   output logic            done,
   output logic [W-1:0]    quotient,
   output logic [W-1:0]    remainder,
   output logic            ovf,
   output logic            dz,
   output logic            quo_we,
   output logic            rem_we,
   output logic [SELW-1:0] quo_wsel,
   output logic [SELW-1:0] rem_wsel
);
   import sdiv_pkg::*;

   localparam int DW = 2 * W;

   if (W < 8 || (W % 2) != 0) begin : g_bad_width
      $error("sdiv64_unit: W must be even and at least 8");
   end
   if (SELW < 1) begin : g_bad_sel
      $error("sdiv64_unit: SELW must be at least 1");
   end

   sdiv_state_e   state_q;

   logic [DW-1:0] dvd_mag;
   logic          dvd_neg;
   logic [W-1:0]  dvs_mag;
   logic          dvs_neg;
   logic          dvs_zero;

   logic          accept;
   logic          core_load;
   logic          core_last;
   logic [DW-1:0] q_mag;
   logic [W-1:0]  r_mag;

   logic          q_neg_q;
   logic          r_neg_q;
   logic          zero_q;

   logic [W-1:0]  fx_quo;
   logic [W-1:0]  fx_rem;
   logic          fx_ovf;

   sdiv_prep #(.W(W)) u_prep (
      .wide     (wide),
      .lo_word  (lo_word),
      .hi_word  (hi_word),
      .divisor  (divisor),
      .dvd_mag  (dvd_mag),
      .dvd_neg  (dvd_neg),
      .dvs_mag  (dvs_mag),
      .dvs_neg  (dvs_neg),
      .dvs_zero (dvs_zero)
   );

   assign accept    = start && (state_q == ST_IDLE);
   assign core_load = accept && !dvs_zero;

   sdiv_core #(.W(W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (core_load),
      .dvd_mag (dvd_mag),
      .dvs_mag (dvs_mag),
      .last    (core_last),
      .q_mag   (q_mag),
      .r_mag   (r_mag)
   );

   sdiv_fixup #(.W(W)) u_fix (
      .q_mag     (q_mag),
      .r_mag     (r_mag),
      .q_neg     (q_neg_q),
      .r_neg     (r_neg_q),
      .zero      (zero_q),
      .quotient  (fx_quo),
      .remainder (fx_rem),
      .ovf       (fx_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         q_neg_q   <= 1'b0;
         r_neg_q   <= 1'b0;
         zero_q    <= 1'b0;
         quo_wsel  <= '0;
         rem_wsel  <= '0;
         quotient  <= '0;
         remainder <= '0;
         ovf       <= 1'b0;
         dz        <= 1'b0;
         done      <= 1'b0;
         quo_we    <= 1'b0;
         rem_we    <= 1'b0;
      end else begin
         done   <= 1'b0;
         quo_we <= 1'b0;
         rem_we <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  q_neg_q  <= dvd_neg ^ dvs_neg;
                  r_neg_q  <= dvd_neg;
                  zero_q   <= dvs_zero;
                  quo_wsel <= quo_sel;
                  rem_wsel <= rem_sel;
                  ovf      <= 1'b0;
                  dz       <= 1'b0;
                  state_q  <= dvs_zero ? ST_FIX : ST_RUN;
               end
            end
            ST_RUN: begin
               if (core_last) begin
                  state_q <= ST_FIX;
               end
            end
            ST_FIX: begin
               quotient  <= fx_quo;
               remainder <= fx_rem;
               ovf       <= fx_ovf;
               dz        <= zero_q;
               done      <= 1'b1;
               quo_we    <= !fx_ovf && !zero_q;
               rem_we    <= !fx_ovf && !zero_q && (quo_wsel != rem_wsel);
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sdiv64_chk.sv
module sdiv64_chk #(
   parameter int W    = 32,
   parameter int SELW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [W-1:0]    divisor,
   input logic            busy,
   input logic            done,
   input logic            ovf,
   input logic            dz,
   input logic            quo_we,
   input logic            rem_we,
   input logic [SELW-1:0] quo_wsel,
   input logic [SELW-1:0] rem_wsel
);
   localparam int LW       = $clog2(2 * W + 3) + 1;
   localparam int LAT_FULL = 2 * W + 2;
   localparam int LAT_ZERO = 2;

   logic [LW-1:0] lat_q;
   logic          zc_q;

   // Edges since the accepting edge, counted independently of the design.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         zc_q  <= 1'b0;
      end else if (start && !busy) begin
         lat_q <= LW'(1);
         zc_q  <= (divisor == '0);
      end else if (busy) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == (zc_q ? LW'(LAT_ZERO) : LW'(LAT_FULL))));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_no_overflow_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> (!quo_we && !rem_we));

   p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zc_q) |-> (dz && !quo_we && !rem_we));

   p_we_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      quo_we |-> (done && !ovf && !dz));

   p_rem_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rem_we |-> (quo_we && (rem_wsel != quo_wsel)));

endmodule

bind sdiv64_unit sdiv64_chk #(.W(W), .SELW(SELW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .divisor  (divisor),
   .busy     (busy),
   .done     (done),
   .ovf      (ovf),
   .dz       (dz),
   .quo_we   (quo_we),
   .rem_we   (rem_we),
   .quo_wsel (quo_wsel),
   .rem_wsel (rem_wsel)
);

// File: tb/tb_sdiv64_unit.sv
`timescale 1ns/1ps
module tb_sdiv64_unit;
   localparam int W    = 32;
   localparam int SELW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            wide = 1'b0;
   logic [W-1:0]    lo_word = '0;
   logic [W-1:0]    hi_word = '0;
   logic [W-1:0]    divisor = '0;
   logic [SELW-1:0] quo_sel = '0;
   logic [SELW-1:0] rem_sel = '0;
   logic            busy, done, ovf, dz, quo_we, rem_we;
   logic [W-1:0]    quotient, remainder;
   logic [SELW-1:0] quo_wsel, rem_wsel;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sdiv64_unit #(.W(W), .SELW(SELW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
      .lo_word(lo_word), .hi_word(hi_word), .divisor(divisor),
      .quo_sel(quo_sel), .rem_sel(rem_sel), .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder), .ovf(ovf), .dz(dz),
      .quo_we(quo_we), .rem_we(rem_we), .quo_wsel(quo_wsel), .rem_wsel(rem_wsel)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One complete operation; expected values come from 66-bit signed arithmetic.
   task automatic run_div(input string tag, input bit wd, input logic [W-1:0] hi,
                          input logic [W-1:0] lo, input logic [W-1:0] dv,
                          input logic [SELW-1:0] qs, input logic [SELW-1:0] rs,
                          input bit poke);
      logic signed [65:0] n, d, q, r;
      bit   e_ovf, e_dz, e_valid;
      logic [W-1:0] e_q, e_r;
      int   e_lat, cyc;
      n = wd ? {{2{hi[W-1]}}, hi, lo} : {{34{lo[W-1]}}, lo};
      d = {{34{dv[W-1]}}, dv};
      e_dz = (dv == '0);
      if (e_dz) begin
         q = '0; r = '0; e_ovf = 0;
      end else begin
         q = n / d;
         r = n % d;
         e_ovf = (q > 66'sd2147483647) || (q < -66'sd2147483648);
      end
      e_valid = !e_dz && !e_ovf;
      e_q     = e_valid ? q[W-1:0] : '0;
      e_r     = e_valid ? r[W-1:0] : '0;
      e_lat   = e_dz ? 1 : 65;

      @(negedge clk);
      wide = wd; hi_word = hi; lo_word = lo; divisor = dv;
      quo_sel = qs; rem_sel = rs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R6", {tag, " busy after accept"}, 64'(busy), 64'd1);
      // Operands may change freely once accepted (R7).
      lo_word = ~lo; hi_word = ~hi; quo_sel = ~qs; rem_sel = ~qs;
      cyc = 0;
      while (!done && cyc < 200) begin
         start = (poke && cyc == 20);
         if (poke && cyc == 20) divisor = 32'd5;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(cyc == e_lat, "R6", {tag, " done latency"}, 64'(cyc), 64'(e_lat));
      chk(quotient == e_q, e_valid ? "R2" : "R3", {tag, " quotient"}, 64'(quotient), 64'(e_q));
      chk(remainder == e_r, e_valid ? "R2" : "R3", {tag, " remainder"}, 64'(remainder), 64'(e_r));
      chk(ovf == e_ovf, "R3", {tag, " ovf flag"}, 64'(ovf), 64'(e_ovf));
      chk(dz == e_dz, "R4", {tag, " dz flag"}, 64'(dz), 64'(e_dz));
      chk(quo_we == e_valid, "R5", {tag, " quo_we"}, 64'(quo_we), 64'(e_valid));
      chk(rem_we == (e_valid && qs != rs), "R5", {tag, " rem_we"},
          64'(rem_we), 64'(e_valid && qs != rs));
      chk(quo_wsel == qs && rem_wsel == rs, "R9", {tag, " write selects"},
          {32'(quo_wsel), 32'(rem_wsel)}, {32'(qs), 32'(rs)});
      chk(busy == 1'b0, "R6", {tag, " busy low at done"}, 64'(busy), 64'd0);
      @(negedge clk);
      chk(!done && !quo_we && !rem_we, "R6", {tag, " strobes one cycle"},
          {61'd0, done, quo_we, rem_we}, 64'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk({busy, done, quo_we, rem_we, ovf, dz} == 6'b0, "R8", "reset outputs",
          64'({busy, done, quo_we, rem_we, ovf, dz}), 64'd0);
   endtask

   task automatic t_narrow();
      run_div("R1 narrow +/+", 1'b0, 32'hDEADBEEF, 32'd100, 32'd7, 3'd1, 3'd2, 1'b0);
      run_div("R2 narrow -/+", 1'b0, 32'h0, -32'sd100, 32'd7, 3'd3, 3'd4, 1'b0);
      run_div("R2 narrow +/-", 1'b0, 32'h12345678, 32'd100, -32'sd7, 3'd5, 3'd6, 1'b0);
      run_div("R2 narrow -/-", 1'b0, 32'h0, -32'sd100, -32'sd7, 3'd0, 3'd7, 1'b0);
   endtask

   task automatic t_wide();
      run_div("R1 wide 2^32/3", 1'b1, 32'h1, 32'h0, 32'd3, 3'd1, 3'd2, 1'b0);
      run_div("R1 wide neg", 1'b1, 32'hFFFFFFFE, 32'h7654321B, 32'd7, 3'd2, 3'd1, 1'b0);
   endtask

   task automatic t_overflow();
      run_div("R3 wide min/-1", 1'b1, 32'h80000000, 32'h0, 32'hFFFFFFFF, 3'd1, 3'd2, 1'b0);
      run_div("R3 narrow min/-1", 1'b0, 32'h0, 32'h80000000, 32'hFFFFFFFF, 3'd1, 3'd2, 1'b0);
      run_div("R3 wide 2^31/1", 1'b1, 32'h0, 32'h80000000, 32'd1, 3'd1, 3'd2, 1'b0);
   endtask

   task automatic t_bounds();
      run_div("R3 max pos", 1'b1, 32'h0, 32'hFFFFFFFE, 32'd2, 3'd1, 3'd2, 1'b0);
      run_div("R3 min neg narrow", 1'b0, 32'h0, 32'h80000000, 32'd1, 3'd1, 3'd2, 1'b0);
      run_div("R3 min neg wide", 1'b1, 32'h0, 32'h80000000, 32'hFFFFFFFF, 3'd1, 3'd2, 1'b0);
   endtask

   task automatic t_zero();
      run_div("R4 zero divisor", 1'b1, 32'h5, 32'h9, 32'd0, 3'd1, 3'd2, 1'b0);
   endtask

   task automatic t_same_sel();
      run_div("R5 equal selects", 1'b0, 32'h0, 32'd1000, 32'd33, 3'd4, 3'd4, 1'b0);
   endtask

   task automatic t_ignore_start();
      run_div("R7 start while busy", 1'b1, 32'h0, 32'd123456789, -32'sd1000, 3'd6, 3'd1, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_narrow();
      t_wide();
      t_overflow();
      t_bounds();
      t_zero();
      t_same_sel();
      t_ignore_start();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule